// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-facing register front end of an I/O interrupt redirection controller. Software never addresses the controller's registers directly. It first writes a register number into an 8-bit select register, then reads or writes a 32-bit data window. Through that window it reaches an identification register, a read-only version register and a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves, and the select value determines both the entry and the half.

The block owns the entry storage and presents every entry, flattened, to the neighbouring service logic. That logic reads the vector, delivery mode, destination mode, polarity, trigger mode, mask, remote-pending flag and destination straight from these outputs. It also reports a completed level-triggered delivery back through a remote-pending set strobe. The block samples the pin request lines into a request register. When software rewrites an entry whose pin is pending, the block emits a one-cycle service request carrying the pin index, so that the new programming is acted on. Resolving targets and delivering interrupts are done elsewhere.

Top module: `ioredir_window`

## Requirements
- R1: On reset, every entry holds only its mask bit (bit 16), so the low half reads 0x0001_0000 and the high half reads 0. The select register, the ID and the request register are cleared.
- R2: The select register is an 8-bit read/write register at offset 0x00. The data window is at offset 0x10. Only address bits 7:0 are decoded. A read from any other offset returns 0.
- R3: With select 0x01, the window reads (pin count − 1) in bits 23:16 and version code 0x11 in bits 7:0. This is 0x0017_0011 for 24 pins. Writes to it change nothing.
- R4: With select 0x00, a window write stores data bits 27:24 as the 4-bit ID. Selects 0x00 and 0x02 both read the ID back in bits 27:24, with all other bits 0. Writes with select 0x02 are ignored.
- R5: A select of 0x10 or above addresses entry (select − 0x10) >> 1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0.
- R6: A window write to an entry index at or beyond the pin count, or with select 0x03 to 0x0F, is dropped. A window read in those cases returns 0.
- R7: Writing the low half of an entry clears its remote-pending flag (bit 14), whatever the written data holds. Writing the high half leaves the flag unchanged. A pulse on rp_set_valid sets the flag of entry rp_set_idx, and this takes precedence over a low-half write to the same entry in the same cycle.
- R8: In the cycle after any accepted entry write, svc_valid is high with svc_idx equal to the entry index, but only if that pin's request bit was set. The request bit is pin_req as registered on the previous clock. Otherwise svc_valid stays low.
- R9: Writes are accepted only when bus_size is 4 or 8. Any other size has no effect. Only bus_wdata bits 31:0 are used.
- R10: entries_o carries entry i in bits [64*i+63 : 64*i]. The fields are: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-pending 14, trigger 15, mask 16 and destination 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 16 | Byte address; bits 7:0 decoded |
| bus_size | input | 4 | Write size in bytes |
| bus_wdata | input | 64 | Write data; bits 31:0 used |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_req | input | 24 | Pin request levels, registered into the request register |
| rp_set_valid | input | 1 | Set remote-pending flag strobe from service logic |
| rp_set_idx | input | 5 | Entry whose remote-pending flag is set |
| entries_o | output | 1536 | All redirection entries, flattened |
| svc_valid | output | 1 | Service request pulse |
| svc_idx | output | 5 | Pin index of the service request |

## Verification
The main function, indirect access, is driven with a table of select and data pairs. The table covers both halves of the first and last valid entries, the first out-of-range index and a hole in the fixed-register space. It also includes the version, ID and arbitration selects, which tells apart correct index arithmetic, half selection and read-only handling. Directed steps exercise the data patterns that expose the remote-pending override: a written 1 in bit 14, a high-half write after a set, and a set colliding with a clear. They also cover a pending pin against a quiet pin for the service pulse, unsupported write sizes, address aliasing above bit 7, and 64-bit data with garbage in the upper word.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;

  localparam int ENT_W   = 64;
  localparam int HALF_W  = 32;

  // field positions inside one entry
  localparam int F_RP    = 14;
  localparam int F_MASK  = 16;

  // fixed register selects
  localparam logic [7:0] SEL_ID   = 8'h00;
  localparam logic [7:0] SEL_VER  = 8'h01;
  localparam logic [7:0] SEL_ARB  = 8'h02;
  localparam logic [7:0] SEL_TBL0 = 8'h10;

  localparam logic [ENT_W-1:0] ENT_RESET = ENT_W'(1) << F_MASK;

  // entry index addressed by a table select value
  function automatic logic [6:0] sel_entry_index(input logic [7:0] s);
    logic [7:0] d;
    d = s - SEL_TBL0;
    return d[7:1];
  endfunction

  // version word: pin count minus one above the version code
  function automatic logic [31:0] version_word(input int npins, input logic [7:0] code);
    logic [7:0] top;
    top = 8'(npins - 1);
    return {8'h00, top, 8'h00, code};
  endfunction

endpackage

// File: rtl/ioredir_decode.sv
module ioredir_decode
  import ioredir_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDXW = $clog2(NPINS)
) (
  input  logic [7:0]      sel,
  output logic            is_id,
  output logic            is_ver,
  output logic            is_arb,
  output logic            ent_ok,
  output logic            ent_hi,
  output logic [IDXW-1:0] ent_idx
);
  logic [6:0] full_idx;

  always_comb begin
    full_idx = sel_entry_index(sel);
    is_id    = (sel == SEL_ID);
    is_ver   = (sel == SEL_VER);
    is_arb   = (sel == SEL_ARB);
    ent_ok   = (sel >= SEL_TBL0) && (int'(full_idx) < NPINS);
    ent_hi   = sel[0];
    ent_idx  = full_idx[IDXW-1:0];
  end
endmodule

// File: rtl/ioredir_entry_table.sv
module ioredir_entry_table
  import ioredir_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDXW = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDXW-1:0]        wr_idx,
  input  logic                   wr_hi,
  input  logic [HALF_W-1:0]      wr_data,
  input  logic                   rp_set_valid,
  input  logic [IDXW-1:0]        rp_set_idx,
  output logic [NPINS*ENT_W-1:0] entries
);
  for (genvar i = 0; i < NPINS; i++) begin : g_ent
    logic [ENT_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= ENT_RESET;
      end else begin
        if (wr_en && wr_idx == IDXW'(i)) begin
          if (wr_hi) begin
            ent_q[ENT_W-1:HALF_W] <= wr_data;
          end else begin
            ent_q[HALF_W-1:0] <= wr_data;
            ent_q[F_RP]       <= 1'b0;
          end
        end
        // completed delivery wins over a same-cycle clear
        if (rp_set_valid && rp_set_idx == IDXW'(i)) ent_q[F_RP] <= 1'b1;
      end
    end
    assign entries[i*ENT_W +: ENT_W] = ent_q;
  end
endmodule

// File: rtl/ioredir_service.sv
module ioredir_service #(
  parameter int NPINS = 24,
  localparam int IDXW = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_req,
  input  logic             ent_wr,
  input  logic [IDXW-1:0]  ent_idx,
  output logic             svc_valid,
  output logic [IDXW-1:0]  svc_idx
);
  logic [NPINS-1:0] irr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q     <= '0;
      svc_valid <= 1'b0;
      svc_idx   <= '0;
    end else begin
      irr_q     <= pin_req;
      svc_valid <= ent_wr && irr_q[ent_idx];
      svc_idx   <= ent_idx;
    end
  end
endmodule

// File: rtl/ioredir_window.sv
module ioredir_window
  import ioredir_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int AW = 16,
  parameter logic [7:0] VER_CODE = 8'h11,
  parameter logic [7:0] OFS_SEL = 8'h00,
  parameter logic [7:0] OFS_WIN = 8'h10,
  localparam int IDXW = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [3:0]             bus_size,
  input  logic [63:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NPINS-1:0]       pin_req,
  input  logic                   rp_set_valid,
  input  logic [IDXW-1:0]        rp_set_idx,
  output logic [NPINS*ENT_W-1:0] entries_o,
  output logic                   svc_valid,
  output logic [IDXW-1:0]        svc_idx
);
  logic [7:0]      sel_q;
  logic [3:0]      id_q;
  logic [7:0]      low_addr;
  logic            size_ok, wr_accept, sel_wr, win_wr, id_wr, ent_wr_ok;
  logic            is_id, is_ver, is_arb, ent_ok, ent_hi;
  logic [IDXW-1:0] ent_idx;
  logic [ENT_W-1:0] cur_ent;
  logic [31:0]     win_rdata;

  assign low_addr  = bus_addr[7:0];
  assign size_ok   = (bus_size == 4'd4) || (bus_size == 4'd8);
  assign wr_accept = bus_wr && size_ok;
  assign sel_wr    = wr_accept && (low_addr == OFS_SEL);
  assign win_wr    = wr_accept && (low_addr == OFS_WIN);

  ioredir_decode #(.NPINS(NPINS)) u_dec (
    .sel(sel_q), .is_id(is_id), .is_ver(is_ver), .is_arb(is_arb),
    .ent_ok(ent_ok), .ent_hi(ent_hi), .ent_idx(ent_idx)
  );

  assign id_wr     = win_wr && is_id;
  assign ent_wr_ok = win_wr && ent_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata[7:0];
      if (id_wr)  id_q  <= bus_wdata[27:24];
    end
  end

  ioredir_entry_table #(.NPINS(NPINS)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ent_wr_ok), .wr_idx(ent_idx), .wr_hi(ent_hi),
    .wr_data(bus_wdata[31:0]),
    .rp_set_valid(rp_set_valid), .rp_set_idx(rp_set_idx),
    .entries(entries_o)
  );

  ioredir_service #(.NPINS(NPINS)) u_svc (
    .clk(clk), .rst_n(rst_n), .pin_req(pin_req),
    .ent_wr(ent_wr_ok), .ent_idx(ent_idx),
    .svc_valid(svc_valid), .svc_idx(svc_idx)
  );

  always_comb begin
    cur_ent = '0;
    if (ent_ok) cur_ent = entries_o[{ent_idx, 6'b0} +: ENT_W];
    if (is_id || is_arb)  win_rdata = {4'h0, id_q, 24'h0};
    else if (is_ver)      win_rdata = version_word(NPINS, VER_CODE);
    else if (ent_ok)      win_rdata = ent_hi ? cur_ent[63:32] : cur_ent[31:0];
    else                  win_rdata = '0;
    if (low_addr == OFS_SEL)      bus_rdata = {24'h0, sel_q};
    else if (low_addr == OFS_WIN) bus_rdata = win_rdata;
    else                          bus_rdata = '0;
  end
endmodule

// File: rtl/ioredir_window_chk.sv
module ioredir_window_chk
  import ioredir_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDXW = $clog2(NPINS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic                   size_ok,
  input logic                   win_wr,
  input logic                   ent_ok,
  input logic                   ent_wr_ok,
  input logic                   ent_hi,
  input logic [IDXW-1:0]        ent_idx,
  input logic                   id_wr,
  input logic [3:0]             id_q,
  input logic [7:0]             sel_q,
  input logic                   rp_set_valid,
  input logic [IDXW-1:0]        rp_set_idx,
  input logic [NPINS*ENT_W-1:0] entries_o,
  input logic                   svc_valid,
  input logic [IDXW-1:0]        svc_idx
);
  logic [NPINS-1:0] rp_vec;
  always_comb
    for (int i = 0; i < NPINS; i++) rp_vec[i] = entries_o[i*ENT_W + F_RP];

  p_svc_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> $past(ent_wr_ok));

  p_svc_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> svc_idx == $past(ent_idx));

  p_low_clears_rp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_wr_ok && !ent_hi && !(rp_set_valid && rp_set_idx == ent_idx))
      |=> !rp_vec[$past(ent_idx)]);

  p_bad_size_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !size_ok && !rp_set_valid) |=> ($stable(entries_o) && $stable(sel_q)));

  p_invalid_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !ent_ok && !rp_set_valid) |=> $stable(entries_o));

  p_id_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !id_wr |=> $stable(id_q));
endmodule

bind ioredir_window ioredir_window_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .size_ok(size_ok),
  .win_wr(win_wr), .ent_ok(ent_ok), .ent_wr_ok(ent_wr_ok), .ent_hi(ent_hi),
  .ent_idx(ent_idx), .id_wr(id_wr), .id_q(id_q), .sel_q(sel_q),
  .rp_set_valid(rp_set_valid), .rp_set_idx(rp_set_idx),
  .entries_o(entries_o), .svc_valid(svc_valid), .svc_idx(svc_idx)
);

// File: tb/ioredir_window_tb.sv
module ioredir_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [3:0]    bus_size = 4'd4;
  logic [63:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_req = '0;
  logic          rp_set_valid = 1'b0;
  logic [4:0]    rp_set_idx = '0;
  logic [NP*64-1:0] entries_o;
  logic          svc_valid;
  logic [4:0]    svc_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ioredir_window dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_req(pin_req), .rp_set_valid(rp_set_valid), .rp_set_idx(rp_set_idx),
    .entries_o(entries_o), .svc_valid(svc_valid), .svc_idx(svc_idx)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [7:0]  sel;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{4'd7, 8'h10, 32'h1234_4321, 32'h1234_0321}, // R7 R5 entry 0 low, bit 14 forced 0
    '{4'd5, 8'h11, 32'hA500_0000, 32'hA500_0000}, // R5 entry 0 high
    '{4'd5, 8'h3F, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R5 entry 23 high
    '{4'd5, 8'h3E, 32'h0000_BFFF, 32'h0000_BFFF}, // R5 entry 23 low
    '{4'd6, 8'h40, 32'h1111_1111, 32'h0000_0000}, // R6 entry 24 out of range
    '{4'd6, 8'h05, 32'h0000_0005, 32'h0000_0000}, // R6 hole in fixed space
    '{4'd3, 8'h01, 32'hFFFF_FFFF, 32'h0017_0011}, // R3 version read-only
    '{4'd4, 8'h02, 32'h0F00_0000, 32'h0000_0000}, // R4 arb write ignored
    '{4'd4, 8'h00, 32'h0A00_0000, 32'h0A00_0000}, // R4 ID write
    '{4'd4, 8'h02, 32'h0500_0000, 32'h0A00_0000}  // R4 arb reads ID
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 4'd4;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    logic all_mask;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    all_mask = 1'b1;
    for (int i = 0; i < NP; i++)
      if (entries_o[i*64 +: 64] !== 64'h1_0000) all_mask = 1'b0;
    chk("R1 entries at reset", all_mask, 1'b1);
    rd(16'h0000, v); chk("R1 select at reset", v, 0);
    rd(16'h0010, v); chk("R1 ID at reset", v, 0);
    chk("R1 no service at reset", svc_valid, 0);
    wr(16'h0000, 4'd4, 64'h1A); rd(16'h0010, v); chk("R1 entry 5 low at reset", v, 32'h0001_0000);

    // R2 select register, alias, stray offset
    rd(16'h0000, v); chk("R2 select readback", v, 32'h1A);
    wr(16'h0100, 4'd4, 64'h3B); rd(16'h0000, v); chk("R2 alias above bit 7", v, 32'h3B);
    rd(16'h0020, v); chk("R2 stray offset", v, 0);

    // table walk: R3 R4 R5 R6 R7
    for (int k = 0; k < 10; k++) begin
      wr(16'h0000, 4'd4, {56'h0, VECS[k].sel});
      wr(16'h0010, 4'd4, {32'h0, VECS[k].wd});
      rd(16'h0010, v);
      chk($sformatf("R%0d table row %0d", VECS[k].rq, k), v, VECS[k].exp);
    end

    // R9 unsupported size and upper data ignored
    wr(16'h0000, 4'd4, 64'h12);
    wr(16'h0010, 4'd2, 64'h55); rd(16'h0010, v); chk("R9 size 2 ignored", v, 32'h0001_0000);
    wr(16'h0000, 4'd1, 64'h14); rd(16'h0000, v); chk("R9 size 1 select kept", v, 32'h12);
    wr(16'h0010, 4'd8, 64'hFFFF_FFFF_0000_00AB); rd(16'h0010, v); chk("R9 8-byte low word", v, 32'hAB);

    // R7 remote-pending set, survives high write, cleared by low write
    @(negedge clk); rp_set_valid = 1'b1; rp_set_idx = 5'd3;
    @(negedge clk); rp_set_valid = 1'b0;
    wr(16'h0000, 4'd4, 64'h16); rd(16'h0010, v); chk("R7 flag set", v, 32'h0001_4000);
    wr(16'h0000, 4'd4, 64'h17); wr(16'h0010, 4'd4, 64'h0);
    chk("R7 high write keeps flag", entries_o[3*64+14], 1'b1);
    wr(16'h0000, 4'd4, 64'h16); wr(16'h0010, 4'd4, 64'h0001_0020);
    rd(16'h0010, v); chk("R7 low write clears flag", v, 32'h0001_0020);
    // R7 set and clear in the same cycle: set wins
    @(negedge clk);
    rp_set_valid = 1'b1; rp_set_idx = 5'd3;
    bus_wr = 1'b1; bus_addr = 16'h0010; bus_wdata = 64'h20;
    @(negedge clk); rp_set_valid = 1'b0; bus_wr = 1'b0;
    chk("R7 set beats clear", entries_o[3*64+14], 1'b1);

    // R8 service request on pending pin only
    @(negedge clk); pin_req = NP'(1) << 6;
    wr(16'h0000, 4'd4, 64'h1D);
    wr(16'h0010, 4'd4, 64'h7700_0000);
    chk("R8 service pulse", svc_valid, 1'b1);
    chk("R8 service index", svc_idx, 5'd6);
    @(negedge clk); chk("R8 pulse is one cycle", svc_valid, 1'b0);
    wr(16'h0000, 4'd4, 64'h1F); wr(16'h0010, 4'd4, 64'h0);
    chk("R8 quiet pin no service", svc_valid, 1'b0);

    // R10 field positions on the flattened output
    chk("R10 destination of entry 6", entries_o[6*64+56 +: 8], 8'h77);
    chk("R10 vector of entry 0", entries_o[0 +: 8], 8'h21);
    chk("R10 mask of entry 5", entries_o[5*64+16], 1'b1);

    done = 1;
    finish_run();
  end
endmodule